// File: doc/BRIEF.md
# Colour STN 16-bit Subpixel Packer

This block sits between a pixel source and a single-scan colour passive matrix panel that takes 16 data bits per shift. It turns each pixel into three one-bit colour subpixels, strings the subpixels of consecutive pixels into one serial stream, and cuts that stream into 16-bit words. Each word is driven onto the panel bus and then latched by the panel on a rising edge of the generated shift clock.

Pixels arrive two per pixel clock whenever both the pixel-valid and display-active inputs are high. Six subpixels go in on each such clock, so a word fills after two or three clocks. A full line therefore gives three shift clock rising edges in every eight pixel clocks, spaced unevenly. When the display period ends with a partial word left over, the block pads that word with zeros and sends it before the line pulse. The line pulse discards any partial word that is still held. A modulation output toggles once at the start of each frame pulse.

Top module: `stn16_packer`

## Requirements
- R1: Subpixels go out in the order R, G, B of the first pixel, then R, G, B of the next pixel, and so on. Within a word, the earliest subpixel is on `fp_data[15]`. On `pix_pair`, bits [5:3] carry the earlier pixel as R, G, B and bits [2:0] carry the later pixel as R, G, B.
- R2: A word is loaded on the clock edge at which the held subpixel count, including the six just accepted, reaches 16 or more. With input on every clock of a line, the shift clock rising edges from line start are spaced 3, 2, 3 clocks apart, repeating. This gives three words per eight clocks, and two loads never fall on consecutive edges.
- R3: `fp_shift` is high for exactly one clock period. It rises on the edge after a word is loaded, and `fp_data` does not change on that rising edge.
- R4: A clock with `pix_valid` low or `disp_en` low accepts no subpixels, and `pix_pair` has no effect on that clock.
- R5: A clock with `pix_valid` low inside the display period delays the stream without losing or reordering any subpixels.
- R6: A partial word left when `disp_en` falls is loaded with zeros in its unused low bits. This happens on the first edge with `disp_en` low at which no word was loaded on the previous edge, so a last in-display load is followed by the padded word two edges later.
- R7: `fp_data` returns to zero on an edge with `disp_en` low, provided no word is loaded on that edge and none was loaded on the previous edge. Outside display, `fp_shift` rises only for the words of R6 or for a load on the last display edge.
- R8: An edge with `line_pulse` high discards any held partial subpixels and accepts no pixels.
- R9: `fp_mod` toggles on the edge where `frame_pulse` is first seen high after being low. Holding `frame_pulse` high gives only one toggle.
- R10: After synchronous reset, `fp_data`, `fp_shift` and `fp_mod` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_valid | input | 1 | Pixel pair on `pix_pair` is valid |
| pix_pair | input | 6 | Two pixels, earlier one in [5:3] (R,G,B), later one in [2:0] |
| disp_en | input | 1 | Horizontal display period active |
| line_pulse | input | 1 | Line pulse from the raster timing block |
| frame_pulse | input | 1 | Frame pulse from the raster timing block |
| fp_data | output | 16 | Panel data bus, earliest subpixel on bit 15 |
| fp_shift | output | 1 | Panel shift clock |
| fp_mod | output | 1 | Panel AC modulation signal |

## Verification
The risky overlap is between the last word loaded inside the display period and the padded leftover word. If both went out on adjacent edges, the shift clock would stay high and the panel would miss a latch. The bench provokes this with a three-pair line, whose third clock loads a word and leaves two subpixels behind. It then checks that exactly two separate shift rises follow, with the padded word second. It also runs lines with stalls and lines that end on a word boundary, and compares every output on every clock against a queue model of the subpixel stream.

// File: rtl/stn16_pkg.sv
// Shared constants for the colour STN subpixel packer.
// Assumes one bit per colour component (no grey shading).
package stn16_pkg;
    localparam int COLOR_COMP = 3;
endpackage

// File: rtl/stn16_subpix_accum.sv
// Subpixel accumulator: appends IN_W subpixels per accepted clock, MSB first,
// and offers a BUS_W word once BUS_W or more are held; after display it offers
// the leftover as a zero-padded word. Assumes BUS_W >= IN_W, so at most one
// word per clock, and that hold blocks a flush right after a previous load.
module stn16_subpix_accum #(
    parameter int BUS_W = 16,
    parameter int IN_W  = 6,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             disp_en,
    input  logic             line_clr,
    input  logic             hold,
    input  logic [IN_W-1:0]  sub_in,
    output logic             word_load,
    output logic [BUS_W-1:0] word,
    output logic [CNT_W-1:0] fill_cnt
);
    localparam int BUF_W = BUS_W - 1 + IN_W;
    localparam logic [CNT_W-1:0] BUS_C = CNT_W'(BUS_W);
    localparam logic [CNT_W-1:0] IN_C  = CNT_W'(IN_W);

    logic [BUF_W-1:0] buf_q;
    logic [BUF_W-1:0] buf_add;
    logic [CNT_W-1:0] fill_q;
    logic [CNT_W-1:0] fill_add;
    logic [CNT_W-1:0] rem;
    logic             emit_full;
    logic             flush;

    // Work out the appended buffer, the word-ready decisions and the word to present.
    always_comb begin
        buf_add   = {buf_q[BUF_W-IN_W-1:0], sub_in};
        fill_add  = fill_q + IN_C;
        rem       = fill_add - BUS_C;
        emit_full = take && !line_clr && (fill_add >= BUS_C);
        flush     = !line_clr && !disp_en && (fill_q != '0) && !hold;
        word      = '0;
        if (emit_full) begin
            word = BUS_W'(buf_add >> rem);
        end else if (flush) begin
            word = BUS_W'(buf_q << (BUS_C - fill_q));
        end
    end

    // Hold the pending subpixels and their count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q  <= '0;
            fill_q <= '0;
        end else if (line_clr) begin
            fill_q <= '0;
        end else if (take) begin
            buf_q  <= buf_add;
            fill_q <= emit_full ? rem : fill_add;
        end else if (flush) begin
            fill_q <= '0;
        end
    end

    assign word_load = emit_full || flush;
    assign fill_cnt  = fill_q;
endmodule

// File: rtl/stn16_shift_gen.sv
// Output stage: registers each offered word onto the panel bus and raises the
// shift clock for one period on the following edge, so the data is settled
// at the rising edge. Clears the bus outside display once no word is in flight.
module stn16_shift_gen #(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_load,
    input  logic [BUS_W-1:0] word,
    input  logic             disp_en,
    output logic             busy,
    output logic [BUS_W-1:0] fp_data,
    output logic             fp_shift
);
    logic load_q;

    // Pipeline the load into a delayed shift pulse and drive the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q   <= 1'b0;
            fp_shift <= 1'b0;
            fp_data  <= '0;
        end else begin
            load_q   <= word_load;
            fp_shift <= load_q;
            if (word_load) begin
                fp_data <= word;
            end else if (!disp_en && !load_q) begin
                fp_data <= '0;
            end
        end
    end

    assign busy = load_q;
endmodule

// File: rtl/stn16_ac_mod.sv
// AC modulation: toggles its output once on each rising edge of the frame
// pulse. Assumes the frame pulse is synchronous to clk.
module stn16_ac_mod (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_pulse,
    output logic fp_mod
);
    logic frame_q;

    // Detect the frame pulse rising edge and flip the modulation level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= 1'b0;
            fp_mod  <= 1'b0;
        end else begin
            frame_q <= frame_pulse;
            if (frame_pulse && !frame_q) begin
                fp_mod <= !fp_mod;
            end
        end
    end
endmodule

// File: rtl/stn16_packer.sv
// Top of the colour STN 16-bit subpixel packer. Takes PIX_PER_BEAT pixels per
// clock during display and produces the panel bus, shift clock and AC
// modulation. Assumes the line pulse arrives at least three clocks after the
// display period ends, so a leftover word is flushed first.
module stn16_packer
    import stn16_pkg::*;
#(
    parameter int BUS_W        = 16,
    parameter int PIX_PER_BEAT = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               pix_valid,
    input  logic [PIX_PER_BEAT*COLOR_COMP-1:0] pix_pair,
    input  logic                               disp_en,
    input  logic                               line_pulse,
    input  logic                               frame_pulse,
    output logic [BUS_W-1:0]                   fp_data,
    output logic                               fp_shift,
    output logic                               fp_mod
);
    localparam int IN_W  = PIX_PER_BEAT * COLOR_COMP;
    localparam int BUF_W = BUS_W - 1 + IN_W;
    localparam int CNT_W = $clog2(BUF_W + 1);

    logic             take;
    logic             word_load;
    logic             hold;
    logic [BUS_W-1:0] word_bus;
    logic [CNT_W-1:0] fill_cnt;

    assign take = pix_valid && disp_en;

    stn16_subpix_accum #(.BUS_W(BUS_W), .IN_W(IN_W), .CNT_W(CNT_W)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .disp_en   (disp_en),
        .line_clr  (line_pulse),
        .hold      (hold),
        .sub_in    (pix_pair),
        .word_load (word_load),
        .word      (word_bus),
        .fill_cnt  (fill_cnt)
    );

    stn16_shift_gen #(.BUS_W(BUS_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_load (word_load),
        .word      (word_bus),
        .disp_en   (disp_en),
        .busy      (hold),
        .fp_data   (fp_data),
        .fp_shift  (fp_shift)
    );

    stn16_ac_mod u_mod (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_pulse (frame_pulse),
        .fp_mod      (fp_mod)
    );
endmodule

// File: rtl/stn16_packer_chk.sv
// Assertion checker for stn16_packer, attached by bind. Observes ports and
// the accumulator-to-output hand-off signals.
module stn16_packer_chk #(
    parameter int BUS_W = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pix_valid,
    input logic             disp_en,
    input logic             line_pulse,
    input logic             frame_pulse,
    input logic [BUS_W-1:0] fp_data,
    input logic             fp_shift,
    input logic             fp_mod,
    input logic             word_load,
    input logic [CNT_W-1:0] fill_cnt
);
    AST_SHIFT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fp_shift |=> !fp_shift); // R3
    AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fp_shift) |-> $stable(fp_data)); // R3
    AST_LOAD_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        word_load |=> !word_load); // R2
    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt < CNT_W'(BUS_W)); // R2
    AST_IDLE_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(pix_valid && disp_en) |=> (fill_cnt <= $past(fill_cnt))); // R4
    AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        line_pulse |=> (fill_cnt == '0)); // R8
    AST_MOD_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_pulse && !$past(frame_pulse)) |=> (fp_mod != $past(fp_mod))); // R9
    AST_MOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_pulse |=> $stable(fp_mod)); // R9
endmodule

bind stn16_packer stn16_packer_chk #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_valid   (pix_valid),
    .disp_en     (disp_en),
    .line_pulse  (line_pulse),
    .frame_pulse (frame_pulse),
    .fp_data     (fp_data),
    .fp_shift    (fp_shift),
    .fp_mod      (fp_mod),
    .word_load   (word_load),
    .fill_cnt    (fill_cnt)
);

// File: tb/stn16_packer_test.sv
// Bench for stn16_packer: a behavioural subpixel queue model compared on
// every clock, plus targeted checks on spacing, flush and modulation.
module stn16_packer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_valid = 1'b0;
    logic [5:0]  pix_pair = '0;
    logic        disp_en = 1'b0;
    logic        line_pulse = 1'b0;
    logic        frame_pulse = 1'b0;
    logic [15:0] fp_data;
    logic        fp_shift;
    logic        fp_mod;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    bit          mq[$];
    logic [15:0] m_data = '0;
    logic        m_shift = 1'b0;
    logic        m_mod = 1'b0;
    bit          m_ldprev = 0;
    bit          m_fprev = 0;
    bit          obs_prev = 0;
    int          rise_t[$];
    logic [15:0] rise_w[$];

    stn16_packer uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_valid   (pix_valid),
        .pix_pair    (pix_pair),
        .disp_en     (disp_en),
        .line_pulse  (line_pulse),
        .frame_pulse (frame_pulse),
        .fp_data     (fp_data),
        .fp_shift    (fp_shift),
        .fp_mod      (fp_mod)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Behavioural model of one clock edge using the inputs driven for it.
    task automatic model_edge();
        logic [15:0] w;
        bit ld;
        w = '0;
        ld = 0;
        if (line_pulse) begin
            mq.delete();
        end else if (pix_valid && disp_en) begin
            for (int i = 5; i >= 0; i--) mq.push_back(pix_pair[i]);
            if (mq.size() >= 16) begin
                for (int i = 15; i >= 0; i--) w[i] = mq.pop_front();
                ld = 1;
            end
        end else if (!disp_en && mq.size() > 0 && !m_ldprev) begin
            for (int i = 15; i >= 0; i--) w[i] = (mq.size() > 0) ? mq.pop_front() : 1'b0;
            ld = 1;
        end
        m_shift = m_ldprev;
        if (ld) m_data = w;
        else if (!disp_en && !m_ldprev) m_data = '0;
        m_ldprev = ld;
        if (frame_pulse && !m_fprev) m_mod = !m_mod;
        m_fprev = frame_pulse;
    endtask

    // Per-clock comparison of all outputs, plus shift rise bookkeeping.
    task automatic compare();
        chk("R1 data", 32'(fp_data), 32'(m_data));
        chk("R3 shift", 32'(fp_shift), 32'(m_shift));
        chk("R9 mod", 32'(fp_mod), 32'(m_mod));
        if (fp_shift && !obs_prev) begin
            rise_t.push_back(cyc);
            rise_w.push_back(fp_data);
        end
        obs_prev = fp_shift;
    endtask

    task automatic step(input logic v, input logic [5:0] d, input logic de,
                        input logic ln, input logic fr);
        @(negedge clk);
        compare();
        pix_valid   = v;
        pix_pair    = d;
        disp_en     = de;
        line_pulse  = ln;
        frame_pulse = fr;
        @(posedge clk);
        cyc++;
        model_edge();
    endtask

    function automatic logic [5:0] pat(input int k, input int seed);
        return 6'((k * 37 + seed * 11 + 5) & 63);
    endfunction

    // One line: display with optional stalls, then blanking (optionally with junk), then line pulse.
    task automatic run_line(input int pairs, input int stall_every, input bit junk, input int seed);
        int k;
        k = 0;
        rise_t.delete();
        rise_w.delete();
        while (k < pairs) begin
            if (stall_every > 0 && (cyc % stall_every) == 0) begin
                step(1'b0, 6'h3F, 1'b1, 1'b0, 1'b0);
            end else begin
                step(1'b1, pat(k, seed), 1'b1, 1'b0, 1'b0);
                k++;
            end
        end
        for (int i = 0; i < 6; i++) step(junk, junk ? 6'h2A : 6'h00, 1'b0, 1'b0, 1'b0);
        step(1'b0, 6'h00, 1'b0, 1'b1, 1'b0);
        step(1'b0, 6'h00, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic idle_end_check(input string req);
        chk(req, 32'(fp_data), 32'h0);
        chk(req, 32'(fp_shift), 32'h0);
    endtask

    initial begin
        logic m0;
        repeat (3) @(negedge clk);
        chk("R10 reset data", 32'(fp_data), 32'h0);
        chk("R10 reset shift", 32'(fp_shift), 32'h0);
        chk("R10 reset mod", 32'(fp_mod), 32'h0);
        rst_n = 1'b1;

        // R2: continuous 64-pixel line, rises spaced 3,2,3 repeating, 12 words.
        run_line(32, 0, 1'b0, 1);
        chk("R2 word count", 32'(rise_t.size()), 32'd12);
        for (int i = 1; i < rise_t.size(); i++) begin
            int expd;
            expd = ((i - 1) % 3 == 1) ? 2 : 3;
            chk("R2 rise spacing", 32'(rise_t[i] - rise_t[i-1]), 32'(expd));
        end
        idle_end_check("R7 idle after line");

        // R1: explicit ordering of the first word.
        rise_t.delete();
        rise_w.delete();
        step(1'b1, 6'b101100, 1'b1, 1'b0, 1'b0);
        step(1'b1, 6'b011001, 1'b1, 1'b0, 1'b0);
        step(1'b1, 6'b110011, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 6; i++) step(1'b0, 6'h00, 1'b0, 1'b0, 1'b0);
        // R6 corner: last display edge loads, padded leftover follows two edges later.
        chk("R6 load then flush rises", 32'(rise_t.size()), 32'd2);
        if (rise_w.size() > 0) chk("R1 first word order", 32'(rise_w[0]), 32'hB19C);
        if (rise_t.size() > 1) begin
            chk("R6 flush word padded", 32'(rise_w[1]), 32'hC000);
            chk("R6 flush spacing", 32'(rise_t[1] - rise_t[0]), 32'd2);
        end
        step(1'b0, 6'h00, 1'b0, 1'b1, 1'b0);

        // R6: 20 pixels = 60 subpixels -> 3 full words and one padded word.
        run_line(10, 0, 1'b0, 2);
        chk("R6 partial line words", 32'(rise_t.size()), 32'd4);
        idle_end_check("R7 idle after partial line");

        // R5: stalls inside display lose nothing.
        run_line(32, 3, 1'b0, 3);
        chk("R5 stalled line words", 32'(rise_t.size()), 32'd12);

        // R4: junk pixels with valid high during blanking are ignored.
        run_line(16, 0, 1'b1, 4);
        chk("R4 junk in blanking words", 32'(rise_t.size()), 32'd6);
        idle_end_check("R4 R7 bus idle with junk");
        rise_t.delete();
        for (int i = 0; i < 8; i++) step(1'b1, 6'h3F, 1'b0, 1'b0, 1'b0);
        chk("R4 valid without display", 32'(rise_t.size()), 32'd0);
        idle_end_check("R4 no output without display");

        // R8: line pulse inside display drops the held partial word.
        rise_t.delete();
        for (int i = 0; i < 5; i++) step(1'b1, pat(i, 5), 1'b1, 1'b0, 1'b0);
        step(1'b0, 6'h00, 1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 6; i++) step(1'b0, 6'h00, 1'b0, 1'b0, 1'b0);
        chk("R8 partial discarded", 32'(rise_t.size()), 32'd1);
        run_line(8, 0, 1'b0, 6);
        chk("R8 next line clean", 32'(rise_t.size()), 32'd3);

        // R9: frame pulse held three clocks toggles once, twice over two frames.
        step(1'b0, 6'h00, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        m0 = fp_mod;
        for (int f = 0; f < 2; f++) begin
            for (int i = 0; i < 3; i++) step(1'b0, 6'h00, 1'b0, 1'b0, 1'b1);
            for (int i = 0; i < 3; i++) step(1'b0, 6'h00, 1'b0, 1'b0, 1'b0);
            @(negedge clk);
            chk("R9 one toggle per frame", 32'(fp_mod), 32'((f == 0) ? !m0 : m0));
        end
        step(1'b0, 6'h00, 1'b0, 1'b0, 1'b0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule